// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a logical address into a physical one. A logical address is a 7-bit segment number and a 16-bit offset. The result is a 24-bit physical address. The block holds a table of 64 segment descriptors. Each descriptor has a 16-bit base, an 8-bit limit and an 8-bit attribute byte. A write port loads one whole descriptor per cycle.

For every request, the low six segment bits pick a descriptor. The block then checks the access against that descriptor's attributes and its limit. It either produces the translated address or reports a fault with a cause code. The response appears one cycle after the request.

The top segment bit acts as a unit select. A unit answers only when that bit equals its `UNIT_SEL` parameter. Two units can therefore sit side by side and together serve all 128 segments.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_fault` are 0, `rsp_cause` is 0 and `rsp_paddr` is 0. Every descriptor comes out of reset with its invalid bit set, so a request to any segment faults with cause 1.
- R2: A request accepted on a clock edge gives its response on the outputs right after the next edge, so the latency is one cycle. When `req_valid` is low, `rsp_valid` is 0 in the following cycle.
- R3: The unit responds only when `req_seg[6]` equals `UNIT_SEL`. For any other request, `rsp_valid`, `rsp_fault` and `rsp_paddr` are all 0 in the following cycle.
- R4: The descriptor is chosen by `req_seg[5:0]`. A descriptor write at index `wr_idx` affects requests presented from the cycle after the write onward. A request presented in the same cycle as the write still sees the old contents.
- R5: A request that is allowed returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = ({base, 8'h00} + offset) truncated to 24 bits. The sum wraps past 24'hFFFFFF.
- R6: The limit is counted in 256-byte blocks. If `req_off[15:8]` > limit, the request faults with cause 5. If `req_off[15:8]` equals the limit, the request is allowed.
- R7: Attribute bit 0 marks the descriptor invalid and gives cause 1. Bit 1 marks it system-only, so a request with `req_sys`=0 gives cause 2.
- R8: `req_kind` encodes the access type: 2'b01 is a data write, 2'b10 is an instruction fetch, and any other value is a data read. Attribute bit 2 means read-only, so a write gives cause 3. Attribute bit 3 means execute-only, so any non-fetch access gives cause 4.
- R9: When several checks fail, the lowest cause number is reported: invalid, then system, then read-only, then execute-only, then limit. Attribute bits 7:4 have no effect on the response.
- R10: Whenever `rsp_fault` is 1, `rsp_valid` is 1, `rsp_cause` is nonzero and `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 6 | Index of the descriptor to write |
| wr_base | input | 16 | New base (physical address bits 23:8) |
| wr_limit | input | 8 | New limit, in 256-byte blocks |
| wr_attr | input | 8 | New attribute byte |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 7 | Segment number; bit 6 is the unit select |
| req_off | input | 16 | Offset within the segment |
| req_kind | input | 2 | Access type: 01 write, 10 fetch, other values read |
| req_sys | input | 1 | Request made in system (privileged) mode |
| rsp_valid | output | 1 | A response from this unit is present |
| rsp_fault | output | 1 | The access was refused |
| rsp_cause | output | 3 | Fault cause, 0 when there is no fault |
| rsp_paddr | output | 24 | Translated physical address, 0 unless the access is allowed |

## Verification
The bench targets the following corner cases. Each one names the failure a wrong design would show.

- Limit boundary: the bench uses an offset whose high byte equals the limit, and one whose high byte is one above it. An off-by-one comparison would fault the first access or pass the second.
- Address wrap: a base near the top of the address space is combined with a large offset. A design that carries a 25th bit, or adds the base unshifted, would return the wrong address.
- Cause priority: one descriptor sets every attribute bit at once and is also over its limit. A wrong order would report the wrong code.
- Unit select: requests with the other value of the unit-select bit must produce no response at all.
- Write timing: a descriptor write and a request land in the same cycle. A design that bypasses the write data would translate through the new contents instead of the old ones.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter bit UNIT_SEL = 1'b0,
  parameter int SEG_W    = 7,
  parameter int OFF_W    = 16,
  parameter int PA_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-2:0] wr_idx,
  input  logic [15:0]      wr_base,
  input  logic [7:0]       wr_limit,
  input  logic [7:0]       wr_attr,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_kind,
  input  logic             req_sys,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [2:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int IDX_W = SEG_W - 1;
  localparam int NDESC = 1 << IDX_W;

  logic [15:0] base_q [NDESC];
  logic [7:0]  lim_q  [NDESC];
  logic [7:0]  attr_q [NDESC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        attr_q[i] <= 8'h01;
      end
    end else if (wr_en) begin
      base_q[wr_idx] <= wr_base;
      lim_q[wr_idx]  <= wr_limit;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  wire [IDX_W-1:0] idx    = req_seg[IDX_W-1:0];
  wire [15:0]      d_base = base_q[idx];
  wire [7:0]       d_lim  = lim_q[idx];
  wire [7:0]       d_attr = attr_q[idx];
  wire             hit    = req_valid && (req_seg[SEG_W-1] == UNIT_SEL);
  wire             is_wr  = (req_kind == 2'b01);
  wire             is_fx  = (req_kind == 2'b10);
  wire [PA_W-1:0]  pa_sum = {d_base, 8'h00} + PA_W'(req_off);

  logic unused_attr;
  assign unused_attr = ^d_attr[7:4];

  logic [2:0] cause;
  always_comb begin
    if (d_attr[0])                 cause = 3'd1;
    else if (d_attr[1] && !req_sys) cause = 3'd2;
    else if (d_attr[2] && is_wr)   cause = 3'd3;
    else if (d_attr[3] && !is_fx)  cause = 3'd4;
    else if (req_off[OFF_W-1:8] > d_lim) cause = 3'd5;
    else                           cause = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= hit;
      rsp_fault <= hit && (cause != 3'd0);
      rsp_cause <= hit ? cause : 3'd0;
      rsp_paddr <= (hit && cause == 3'd0) ? pa_sum : '0;
    end
  end

  AST_FAULT_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_cause != 3'd0 && rsp_paddr == '0)); // R10
  AST_RESPONSE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_seg[SEG_W-1] == UNIT_SEL)); // R3
  AST_IDLE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_ALLOWED_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> ($past(req_off[OFF_W-1:8]) <= $past(d_lim))); // R6
  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(d_attr[0])) |-> (rsp_fault && rsp_cause == 3'd1)); // R7
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [15:0] wr_base = 0;
  logic [7:0]  wr_limit = 0;
  logic [7:0]  wr_attr = 0;
  logic        req_valid = 0;
  logic [6:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic [1:0]  req_kind = 0;
  logic        req_sys = 0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [23:0] rsp_paddr;

  localparam bit SEL = 1'b1;

  seg_xlate #(.UNIT_SEL(SEL)) i_seg_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_attr(wr_attr), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_kind(req_kind), .req_sys(req_sys), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [15:0] mb [64];
  logic [7:0]  ml [64];
  logic [7:0]  ma [64];

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [2:0] ecause(input logic [5:0] i, input logic [15:0] o,
                                        input logic [1:0] k, input logic sy);
    if (ma[i][0]) return 3'd1;
    if (ma[i][1] && !sy) return 3'd2;
    if (ma[i][2] && k == 2'b01) return 3'd3;
    if (ma[i][3] && k != 2'b10) return 3'd4;
    if (o[15:8] > ml[i]) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [23:0] epa(input logic [5:0] i, input logic [15:0] o);
    return {mb[i], 8'h00} + {8'h00, o};
  endfunction

  task automatic load(input logic [5:0] i, input logic [15:0] b, input logic [7:0] l,
                      input logic [7:0] a);
    wr_en = 1; wr_idx = i; wr_base = b; wr_limit = l; wr_attr = a;
    @(negedge clk);
    wr_en = 0;
    mb[i] = b; ml[i] = l; ma[i] = a;
  endtask

  task automatic access(input string r, input logic [6:0] s, input logic [15:0] o,
                        input logic [1:0] k, input logic sy);
    logic hit;
    logic [2:0] c;
    logic [23:0] p;
    hit = (s[6] == SEL);
    c = hit ? ecause(s[5:0], o, k, sy) : 3'd0;
    p = (hit && c == 0) ? epa(s[5:0], o) : 24'd0;
    req_valid = 1; req_seg = s; req_off = o; req_kind = k; req_sys = sy;
    @(negedge clk);
    req_valid = 0;
    check({r, " valid"}, rsp_valid, hit);
    check({r, " fault"}, rsp_fault, hit && c != 0);
    check({r, " cause"}, rsp_cause, c);
    check({r, " paddr"}, rsp_paddr, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 64; i++) begin mb[i] = 0; ml[i] = 0; ma[i] = 8'h01; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", rsp_valid, 0);
    check("R1 fault", rsp_fault, 0);
    check("R1 cause", rsp_cause, 0);
    check("R1 paddr", rsp_paddr, 0);
    rst_n = 1;
    @(negedge clk);
    access("R1 invalid after reset", {SEL, 6'd17}, 16'h0100, 2'b00, 1);
    // R2 idle gives no response
    @(negedge clk);
    check("R2 idle", rsp_valid, 0);
    // R5 translation and wrap
    load(6'd3, 16'h1234, 8'hFF, 8'h00);
    access("R5 basic", {SEL, 6'd3}, 16'hABCD, 2'b00, 0);
    load(6'd4, 16'hFFFF, 8'hFF, 8'h00);
    access("R5 wrap", {SEL, 6'd4}, 16'hF0F0, 2'b10, 0);
    // R6 limit boundary
    load(6'd5, 16'h0200, 8'h3A, 8'h00);
    access("R6 at limit", {SEL, 6'd5}, 16'h3AFF, 2'b00, 0);
    access("R6 over limit", {SEL, 6'd5}, 16'h3B00, 2'b00, 0);
    // R7 system-only
    load(6'd6, 16'h0400, 8'hFF, 8'h02);
    access("R7 user to system", {SEL, 6'd6}, 16'h0010, 2'b00, 0);
    access("R7 system ok", {SEL, 6'd6}, 16'h0010, 2'b00, 1);
    // R8 read-only and execute-only
    load(6'd7, 16'h0800, 8'hFF, 8'h04);
    access("R8 write read-only", {SEL, 6'd7}, 16'h0020, 2'b01, 1);
    access("R8 read read-only", {SEL, 6'd7}, 16'h0020, 2'b11, 1);
    load(6'd8, 16'h0900, 8'hFF, 8'h08);
    access("R8 read exec-only", {SEL, 6'd8}, 16'h0030, 2'b00, 1);
    access("R8 fetch exec-only", {SEL, 6'd8}, 16'h0030, 2'b10, 1);
    // R9 priority and reserved bits
    load(6'd9, 16'h0A00, 8'h00, 8'h0F);
    access("R9 all set", {SEL, 6'd9}, 16'hFF00, 2'b01, 0);
    load(6'd9, 16'h0A00, 8'h00, 8'h0E);
    access("R9 no invalid", {SEL, 6'd9}, 16'hFF00, 2'b01, 0);
    load(6'd9, 16'h0A00, 8'h00, 8'h0C);
    access("R9 system mode", {SEL, 6'd9}, 16'hFF00, 2'b01, 1);
    load(6'd10, 16'h0B00, 8'h10, 8'hF0);
    access("R9 reserved bits", {SEL, 6'd10}, 16'h1000, 2'b01, 0);
    // R3 other unit
    access("R3 other unit", {~SEL, 6'd3}, 16'h0000, 2'b00, 1);
    // R4 write and request in the same cycle see old contents
    wr_en = 1; wr_idx = 6'd3; wr_base = 16'h5555; wr_limit = 8'h00; wr_attr = 8'h01;
    req_valid = 1; req_seg = {SEL, 6'd3}; req_off = 16'h0101; req_kind = 2'b00; req_sys = 0;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R4 same cycle fault", rsp_fault, 0);
    check("R4 same cycle paddr", rsp_paddr, 24'h123501);
    mb[3] = 16'h5555; ml[3] = 8'h00; ma[3] = 8'h01;
    access("R4 after write", {SEL, 6'd3}, 16'h0101, 2'b00, 0);
    // random mix (R4 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 8) == 0) begin
        logic [7:0] a;
        a = $urandom;
        if ($urandom % 2) a[3:0] = 4'h0;
        load($urandom, $urandom, $urandom, a);
      end
      access("R10 random", $urandom, $urandom, $urandom, $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule